// File: doc/BRIEF.md
# Multi-Cycle Unsigned Restoring Divider

This block divides an unsigned dividend by an unsigned WIDTH-bit divisor over several clocks. It returns a WIDTH-bit quotient and a WIDTH-bit remainder. The dividend is normally twice the divisor's width and is given as a high half and a low half. A mode input selects a single-length dividend instead. In that mode the high half is treated as zero, and only the low half is divided.

A start pulse first checks the operands. If the divisor is zero, or if it is not larger than the dividend's high half, the quotient could not fit in WIDTH bits. In that case the block reports an error on the next clock and does no iteration. Otherwise it loads its partial-remainder and quotient registers and runs one shift-subtract-restore step per clock, producing quotient bits from most significant to least significant. After WIDTH steps it pulses `done`, with the quotient and the remainder held on the outputs.

Top module: `restoring_divider`

## Requirements
- R1: After synchronous reset, `done`, `err_div0` and `err_ovf` are 0 and `quotient` and `remainder` are 0.
- R2: For a legal double-length operation, with dividend D = {dvd_hi, dvd_lo}, `done` is high exactly WIDTH clocks after the clock edge that samples `start`. In that cycle `quotient` equals D / divisor and `remainder` equals D mod divisor. Example at WIDTH=4: 0xC9 / 0xF gives 0xD remainder 0x6.
- R3: A start with divisor 0 gives `done`=1, `err_div0`=1 and `err_ovf`=0 in the cycle right after the sampling edge, and no iteration takes place.
- R4: A start with a nonzero divisor that is less than or equal to the effective high half gives `done`=1, `err_ovf`=1 and `err_div0`=0 in the cycle right after the sampling edge. The two error flags are never high together.
- R5: When `single_len`=1, `dvd_hi` has no effect: the dividend is `dvd_lo`, and quotient overflow cannot be flagged.
- R6: On every successful completion, quotient*divisor+remainder equals the dividend and remainder < divisor.
- R7: A `start` pulse while an operation is in progress is ignored. The running operation completes with its own result and its own timing.
- R8: The error flags, `quotient` and `remainder` hold their values after `done` until the next accepted start. A successful start clears both error flags.
- R9: `done` is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| single_len | input | 1 | 1: dividend is dvd_lo only |
| dvd_hi | input | WIDTH | Upper half of the dividend |
| dvd_lo | input | WIDTH | Lower half of the dividend |
| divisor | input | WIDTH | Divisor |
| quotient | output | WIDTH | Quotient result |
| remainder | output | WIDTH | Remainder result |
| done | output | 1 | One-cycle completion pulse |
| err_div0 | output | 1 | Divisor was zero |
| err_ovf | output | 1 | Quotient would not fit in WIDTH bits |

## Verification
At WIDTH=4 every combination of high half, low half and divisor is tried in both modes. This separates the three outcomes: divide-by-zero, overflow at the boundary where the divisor equals the high half, and legal division. In single-length mode the high half is swept through all values, which shows whether it leaks into the result or the overflow check. A short table covers the worked example, which includes one restoring step, along with all-ones operands and a zero dividend. Directed cases then check reset, a start pulse during a running operation, and that results and flags hold after completion.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rdiv_state_e;

    typedef struct packed {
        logic div0;
        logic ovf;
    } rdiv_err_t;

    // Divide-by-zero takes priority over overflow.
    function automatic rdiv_err_t rdiv_classify(input logic dvs_zero,
                                                input logic dvs_not_above);
        rdiv_err_t e;
        e.div0 = dvs_zero;
        e.ovf  = !dvs_zero && dvs_not_above;
        return e;
    endfunction

    function automatic logic rdiv_any_err(input rdiv_err_t e);
        return e.div0 | e.ovf;
    endfunction

endpackage

// File: rtl/rdiv_precheck.sv
module rdiv_precheck
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             single_len,
    input  logic [WIDTH-1:0] dvd_hi,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] acc_init,
    output rdiv_err_t        err
);
    logic dvs_zero;
    logic dvs_not_above;

    always_comb begin
        acc_init      = single_len ? '0 : dvd_hi;
        dvs_zero      = (divisor == '0);
        dvs_not_above = (divisor <= acc_init);
        err           = rdiv_classify(dvs_zero, dvs_not_above);
    end

    always_comb begin
        if (err.div0 || err.ovf)
            AST_ERR_ONE_KIND: assert (!(err.div0 && err.ovf)); // R4
    end
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mq,
    input  logic [WIDTH-1:0] dvs,
    output logic [WIDTH-1:0] acc_next,
    output logic [WIDTH-1:0] mq_next,
    output logic             sub_ok
);
    // The shifted partial remainder includes the carry bit that leaves the accumulator.
    logic [WIDTH:0]   shifted;
    logic [WIDTH+1:0] trial;

    always_comb begin
        shifted  = {acc, mq[WIDTH-1]};
        trial    = {1'b0, shifted} - {2'b00, dvs};
        sub_ok   = !trial[WIDTH+1];
        // Restore is a select: the unsubtracted value is kept on a borrow.
        acc_next = sub_ok ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
        mq_next  = {mq[WIDTH-2:0], sub_ok};
    end

    always_comb begin
        if (acc < dvs)
            AST_STEP_KEEPS_BOUND: assert (acc_next < dvs); // R6
    end
endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step_en,
    input  logic [WIDTH-1:0] acc_init,
    input  logic [WIDTH-1:0] mq_init,
    input  logic [WIDTH-1:0] dvs_init,
    output logic [WIDTH-1:0] acc_q,
    output logic [WIDTH-1:0] mq_q,
    output logic [WIDTH-1:0] dvs_q
);
    logic [WIDTH-1:0] acc_nx;
    logic [WIDTH-1:0] mq_nx;
    logic             ok_bit;

    rdiv_step #(.WIDTH(WIDTH)) step_i (
        .acc      (acc_q),
        .mq       (mq_q),
        .dvs      (dvs_q),
        .acc_next (acc_nx),
        .mq_next  (mq_nx),
        .sub_ok   (ok_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            mq_q  <= '0;
            dvs_q <= '0;
        end else if (load) begin
            acc_q <= acc_init;
            mq_q  <= mq_init;
            dvs_q <= dvs_init;
        end else if (step_en) begin
            acc_q <= acc_nx;
            mq_q  <= mq_nx;
        end
    end

    AST_ACC_BELOW_DVS: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (acc_q < dvs_q)); // R6

    AST_QBIT_MATCHES: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (mq_q[0] == $past(ok_bit))); // R2
endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  rdiv_err_t pre_err,
    output logic      load,
    output logic      step_en,
    output logic      done,
    output rdiv_err_t err_q
);
    localparam int               CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WIDTH - 1);

    rdiv_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    always_comb begin
        accept  = (state_q == ST_IDLE) && start;
        load    = accept && !rdiv_any_err(pre_err);
        step_en = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
            err_q   <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        err_q <= pre_err;
                        cnt_q <= '0;
                        if (rdiv_any_err(pre_err)) begin
                            done <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(err_q.div0 && err_q.ovf)); // R4

    AST_DIV0_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q.div0) |-> done); // R3

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && start && cnt_q != LAST) |=> (state_q == ST_RUN)); // R7

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(err_q)); // R8
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             single_len,
    input  logic [WIDTH-1:0] dvd_hi,
    input  logic [WIDTH-1:0] dvd_lo,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             done,
    output logic             err_div0,
    output logic             err_ovf
);
    logic [WIDTH-1:0] acc_init;
    logic [WIDTH-1:0] dvs_q;
    rdiv_err_t        pre_err;
    rdiv_err_t        err_q;
    logic             load;
    logic             step_en;

    rdiv_precheck #(.WIDTH(WIDTH)) pre_i (
        .single_len (single_len),
        .dvd_hi     (dvd_hi),
        .divisor    (divisor),
        .acc_init   (acc_init),
        .err        (pre_err)
    );

    rdiv_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .pre_err (pre_err),
        .load    (load),
        .step_en (step_en),
        .done    (done),
        .err_q   (err_q)
    );

    rdiv_datapath #(.WIDTH(WIDTH)) dp_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step_en  (step_en),
        .acc_init (acc_init),
        .mq_init  (dvd_lo),
        .dvs_init (divisor),
        .acc_q    (remainder),
        .mq_q     (quotient),
        .dvs_q    (dvs_q)
    );

    assign err_div0 = err_q.div0;
    assign err_ovf  = err_q.ovf;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (done && !err_div0 && !err_ovf) |-> (remainder < dvs_q)); // R6
endmodule

// File: tb/restoring_divider_tb_top.sv
module restoring_divider_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         single_len = 1'b0;
    logic [W-1:0] dvd_hi = '0;
    logic [W-1:0] dvd_lo = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         done;
    logic         err_div0;
    logic         err_ovf;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    restoring_divider #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .single_len(single_len),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .quotient(quotient), .remainder(remainder), .done(done),
        .err_div0(err_div0), .err_ovf(err_ovf)
    );

    // {single, hi, lo, divisor, quotient, remainder, div0, ovf}
    localparam logic [22:0] VEC [10] = '{
        {1'b0, 4'hC, 4'h9, 4'hF, 4'hD, 4'h6, 1'b0, 1'b0},
        {1'b0, 4'h0, 4'h7, 4'h2, 4'h3, 4'h1, 1'b0, 1'b0},
        {1'b0, 4'hE, 4'hF, 4'hF, 4'hF, 4'hE, 1'b0, 1'b0},
        {1'b0, 4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0},
        {1'b0, 4'h5, 4'h0, 4'h5, 4'h0, 4'h0, 1'b0, 1'b1},
        {1'b0, 4'hF, 4'hF, 4'h1, 4'h0, 4'h0, 1'b0, 1'b1},
        {1'b1, 4'hF, 4'h9, 4'h4, 4'h2, 4'h1, 1'b0, 1'b0},
        {1'b1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0},
        {1'b1, 4'h7, 4'hF, 4'h1, 4'hF, 4'h0, 1'b0, 1'b0},
        {1'b0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 1'b0, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Launch one operation; lat is the number of edges after the start edge until done (-1: never).
    task automatic do_op(input logic s, input logic [W-1:0] hi, input logic [W-1:0] lo,
                         input logic [W-1:0] d, output int lat);
        @(negedge clk);
        single_len = s; dvd_hi = hi; dvd_lo = lo; divisor = d; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        if (done) lat = 0;
        else begin
            for (int k = 1; k <= W + 4; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (done) begin lat = k; break; end
            end
        end
    endtask

    task automatic op_and_check(input logic s, input logic [W-1:0] hi, input logic [W-1:0] lo,
                                input logic [W-1:0] d, input string tag);
        int lat;
        int dd, eq, er;
        logic ez, eo;
        dd = s ? int'(lo) : int'({hi, lo});
        ez = (d == 0);
        eo = !ez && !s && (d <= hi);
        do_op(s, hi, lo, d, lat);
        if (ez || eo) begin
            check(lat == 0, {tag, " R3/R4 error latency"}, lat, 0);
            check(err_div0 == ez && err_ovf == eo, {tag, ez ? " R3 flags" : " R4 flags"},
                  {err_div0, err_ovf}, {ez, eo});
        end else begin
            eq = dd / int'(d);
            er = dd % int'(d);
            check(lat == W, {tag, " R2 latency"}, lat, W);
            check(int'(quotient) == eq && int'(remainder) == er,
                  {tag, s ? " R5 result" : " R2 result"},
                  int'({quotient, remainder}), (eq << W) | er);
            check(int'(quotient) * int'(d) + int'(remainder) == dd && remainder < d,
                  {tag, " R6 identity"}, int'(quotient) * int'(d) + int'(remainder), dd);
            check(!err_div0 && !err_ovf, {tag, " R8 flags cleared"}, {err_div0, err_ovf}, 0);
        end
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int lat;
        logic [W-1:0] q0, r0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!done && !err_div0 && !err_ovf && quotient == 0 && remainder == 0,
              "R1 reset state", {done, err_div0, err_ovf, quotient, remainder}, 0);

        // Table walk
        for (int i = 0; i < 10; i++) begin
            op_and_check(VEC[i][22], VEC[i][21:18], VEC[i][17:14], VEC[i][13:10], "table");
            if (VEC[i][1] || VEC[i][0])
                check(err_div0 == VEC[i][1] && err_ovf == VEC[i][0], "table R3/R4 vector flags",
                      {err_div0, err_ovf}, VEC[i][1:0]);
            else
                check(quotient == VEC[i][9:6] && remainder == VEC[i][5:2], "table R2 vector result",
                      {quotient, remainder}, VEC[i][9:2]);
        end

        // R8/R9: after done, outputs hold and done drops
        op_and_check(1'b0, 4'hC, 4'h9, 4'hF, "hold");
        q0 = quotient; r0 = remainder;
        @(posedge clk); @(negedge clk);
        check(!done, "R9 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        check(quotient == q0 && remainder == r0, "R8 results hold", {quotient, remainder}, {q0, r0});
        op_and_check(1'b0, 4'h1, 4'h0, 4'h0, "hold_err");
        repeat (3) @(negedge clk);
        check(err_div0 && !err_ovf && !done, "R8 error flag holds", {err_div0, err_ovf, done}, 2'b10);

        // R7: start pulse during a running operation is ignored
        @(negedge clk);
        single_len = 1'b0; dvd_hi = 4'hC; dvd_lo = 4'h9; divisor = 4'hF; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        single_len = 1'b1; dvd_lo = 4'h3; divisor = 4'h0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(!done && !err_div0, "R7 busy start no error", {done, err_div0}, 0);
        lat = 1;
        while (!done && lat < W + 4) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
        check(lat == W, "R7 original latency", lat, W);
        check(quotient == 4'hD && remainder == 4'h6 && !err_div0, "R7 original result",
              {quotient, remainder}, {4'hD, 4'h6});
        @(posedge clk); @(negedge clk);
        check(!done, "R7 R9 no second done", done, 0);

        // Exhaustive sweep in both modes (R2, R3, R4, R5, R6)
        for (int s = 0; s < 2; s++)
            for (int h = 0; h < 16; h++)
                for (int l = 0; l < 16; l++)
                    for (int d = 0; d < 16; d++)
                        op_and_check(s[0], 4'(h), 4'(l), 4'(d), s ? "sweep_single" : "sweep_double");

        // R1 reset again clears flags and results
        op_and_check(1'b0, 4'h2, 4'h0, 4'h2, "pre_reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(!done && !err_div0 && !err_ovf && quotient == 0 && remainder == 0,
              "R1 reset clears", {done, err_div0, err_ovf, quotient, remainder}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule